// File: doc/BRIEF.md
# Host Transmit Byte Queue with Ninth-Bit Staging

This block buffers outgoing characters between a host and a downstream serializer. The host writes bytes one at a time into a 16-deep queue. Each stored entry is 9 bits wide. The extra bit comes from a separate staging register that the host loads before the byte it belongs to. The serializer removes entries with a single-cycle pop strobe. It receives the oldest entry on a registered data output.

The queue reports two status flags: room for at least one more byte, and an occupancy of eight or more. When the interrupt enable is on, it raises a level interrupt request each time the occupancy flag changes in either direction. The request stays asserted until the host acknowledges it. A source-select input chooses whether transmit data comes from the queue or from a serial input pin. That choice is forced to the queue whenever bit-oriented framing mode is selected. A queue-enable input shrinks the queue to a single holding entry. Sticky flags record writes that were dropped and pops that found nothing to take.

Top module: `host_tx_fifo`

## Requirements
- R1: After a synchronous reset the queue is empty, and the outputs read as follows: `not_full`=1, `half_full`=0, `irq`=0, `overflow`=0, `underrun`=0, `pop_data`=0.
- R2: Entries leave in write order. A pop accepted at a clock edge presents the entry on `pop_data` after that same edge. `pop_data[8]` holds the ninth bit and `pop_data[7:0]` holds the byte.
- R3: With `cfg_fifo_en`=1, `half_full` is 1 exactly when the queue holds 8 or more entries.
- R4: `not_full` is 0 exactly when every entry is occupied: 16 entries with `cfg_fifo_en`=1, or 1 entry with `cfg_fifo_en`=0.
- R5: With `cfg_irq_en`=1, every 0-to-1 or 1-to-0 change of `half_full` sets `irq`, and `irq` stays 1 until `irq_ack` is pulsed. With `cfg_irq_en`=0, changes of `half_full` leave `irq` at 0.
- R6: A `ninth_wr` pulse loads `ninth_val` into the staging register, and that register must be loaded in an earlier cycle than the byte write. A byte write stores the staged value as bit 8 only when `cfg_par_en`, `cfg_stuff_sel` and `cfg_wide8` are all 1. In every other case it stores 0.
- R7: The queue path is active when `cfg_par_mode` or `cfg_hdlc` is 1, and `src_fifo` shows this one cycle later. While the path is inactive, `host_wr` and `ser_pop` are ignored and `tx_bit` repeats `ser_in` one cycle later. While the path is active, `tx_bit` is 0.
- R8: With `cfg_fifo_en`=0, the queue holds a single entry and `half_full` stays 0.
- R9: A write when `not_full` is 0 is dropped and leaves the contents unchanged. It also sets the sticky `overflow` flag.
- R10: A pop from an empty queue leaves `pop_data` at the last entry delivered and sets the sticky `underrun` flag.
- R11: A `flag_clr` pulse clears `overflow` and `underrun`. A new event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_par_mode | input | 1 | Selects the queue as the transmit source |
| cfg_hdlc | input | 1 | Bit-oriented framing mode; forces the queue source |
| cfg_fifo_en | input | 1 | 1: 16-entry queue; 0: single holding entry |
| cfg_par_en | input | 1 | Parity enabled |
| cfg_stuff_sel | input | 1 | Stuffed parity selected |
| cfg_wide8 | input | 1 | Eight-bit word size |
| cfg_irq_en | input | 1 | Enables the occupancy-change interrupt |
| ninth_wr | input | 1 | Loads the ninth-bit staging register |
| ninth_val | input | 1 | Value for the staging register |
| host_wr | input | 1 | Byte write strobe |
| host_byte | input | 8 | Byte to queue |
| irq_ack | input | 1 | Clears the interrupt request |
| flag_clr | input | 1 | Clears the sticky overflow and underrun flags |
| ser_in | input | 1 | Serial transmit data pin |
| ser_pop | input | 1 | Pop strobe from the serializer |
| pop_data | output | 9 | Popped entry, ninth bit in bit 8 |
| tx_bit | output | 1 | Registered serial pass-through bit |
| src_fifo | output | 1 | Queue path is active |
| not_full | output | 1 | At least one entry is free |
| half_full | output | 1 | Eight or more entries are held |
| irq | output | 1 | Interrupt request level |
| overflow | output | 1 | Sticky flag for a dropped write |
| underrun | output | 1 | Sticky flag for an empty pop |

## Verification
Every result of this block is registered, and each one is due exactly one clock edge after the stimulus that causes it. This covers the status flags, the interrupt, the sticky flags, `pop_data`, `tx_bit` and `src_fifo`. The bench applies a write, pop, staging write or acknowledge for exactly one edge. It then samples the outputs one time unit after that edge, so each check reads the first cycle in which the result is due. The sweeps step through every occupancy from 0 to 16 and back down, and through all eight combinations of the three ninth-bit conditions.

// File: rtl/txq_pkg.sv
package txq_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              ninth;
    logic [BYTE_W-1:0] payload;
  } txq_entry_t;

  localparam int unsigned ENTRY_W = $bits(txq_entry_t);
endpackage

// File: rtl/txq_mem.sv
module txq_mem #(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1,
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          fifo_en,
  input  logic          irq_en,
  input  logic          irq_ack,
  input  logic          flag_clr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          empty,
  output logic          not_full,
  output logic          half_full,
  output logic          irq,
  output logic          overflow,
  output logic          underrun
);
  logic [CW-1:0] cnt_q, cnt_nx, limit;
  logic          accept, take, half_nx, nf_nx;

  always_comb begin
    limit   = fifo_en ? CW'(DEPTH) : CW'(1);
    accept  = push_req && (cnt_q < limit);
    take    = pop_req && (cnt_q != '0);
    cnt_nx  = cnt_q + CW'(accept) - CW'(take);
    half_nx = fifo_en && (cnt_nx >= CW'(HALF));
    nf_nx   = cnt_nx < limit;
  end

  assign mem_we = accept;
  assign mem_re = take;
  assign empty  = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      wptr      <= '0;
      rptr      <= '0;
      half_full <= 1'b0;
      not_full  <= 1'b1;
      irq       <= 1'b0;
      overflow  <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      cnt_q     <= cnt_nx;
      half_full <= half_nx;
      not_full  <= nf_nx;
      if (accept) wptr <= wptr + AW'(1);
      if (take)   rptr <= rptr + AW'(1);
      if (irq_en && (half_nx != half_full)) irq <= 1'b1;
      else if (irq_ack)                      irq <= 1'b0;
      if (push_req && !accept) overflow <= 1'b1;
      else if (flag_clr)       overflow <= 1'b0;
      if (pop_req && !take)    underrun <= 1'b1;
      else if (flag_clr)       underrun <= 1'b0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push_req && !not_full && !pop_req) |=> $stable(cnt_q) && overflow); // R9
  AST_IRQ_EDGE: assert property (@(posedge clk) disable iff (rst)
    (irq_en && (half_nx != half_full)) |=> irq); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq); // R5
  AST_HALF_GATED: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> !half_full); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow && !flag_clr) |=> overflow); // R11
endmodule

// File: rtl/host_tx_fifo.sv
module host_tx_fifo
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_par_mode,
  input  logic               cfg_hdlc,
  input  logic               cfg_fifo_en,
  input  logic               cfg_par_en,
  input  logic               cfg_stuff_sel,
  input  logic               cfg_wide8,
  input  logic               cfg_irq_en,
  input  logic               ninth_wr,
  input  logic               ninth_val,
  input  logic               host_wr,
  input  logic [BYTE_W-1:0]  host_byte,
  input  logic               irq_ack,
  input  logic               flag_clr,
  input  logic               ser_in,
  input  logic               ser_pop,
  output logic [ENTRY_W-1:0] pop_data,
  output logic               tx_bit,
  output logic               src_fifo,
  output logic               not_full,
  output logic               half_full,
  output logic               irq,
  output logic               overflow,
  output logic               underrun
);
  logic       ninth_q;
  logic       path_on, push_eff, pop_eff, ninth_use;
  txq_entry_t wr_entry;
  logic          we, re, q_empty;
  logic [AW-1:0] wptr, rptr;

  assign path_on   = cfg_par_mode | cfg_hdlc;
  assign push_eff  = host_wr & path_on;
  assign pop_eff   = ser_pop & path_on;
  assign ninth_use = cfg_par_en & cfg_stuff_sel & cfg_wide8;

  always_comb begin
    wr_entry.ninth   = ninth_use & ninth_q;
    wr_entry.payload = host_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ninth_q  <= 1'b0;
      src_fifo <= 1'b0;
      tx_bit   <= 1'b0;
    end else begin
      if (ninth_wr) ninth_q <= ninth_val;
      src_fifo <= path_on;
      tx_bit   <= path_on ? 1'b0 : ser_in;
    end
  end

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_eff),
    .pop_req  (pop_eff),
    .fifo_en  (cfg_fifo_en),
    .irq_en   (cfg_irq_en),
    .irq_ack  (irq_ack),
    .flag_clr (flag_clr),
    .mem_we   (we),
    .mem_re   (re),
    .wptr     (wptr),
    .rptr     (rptr),
    .empty    (q_empty),
    .not_full (not_full),
    .half_full(half_full),
    .irq      (irq),
    .overflow (overflow),
    .underrun (underrun)
  );

  txq_mem #(.DW(ENTRY_W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .rst  (rst),
    .we   (we),
    .waddr(wptr),
    .wdata(wr_entry),
    .re   (re),
    .raddr(rptr),
    .rdata(pop_data)
  );

  AST_UDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pop_eff && q_empty) |=> ($stable(pop_data) && underrun)); // R10
  AST_SERIAL_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (!path_on && (host_wr || ser_pop) && !flag_clr) |=>
      ($stable(overflow) && $stable(underrun) && $stable(pop_data))); // R7
endmodule

// File: tb/host_tx_fifo_tb.sv
module host_tx_fifo_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_par_mode = 1'b1, cfg_hdlc = 1'b0, cfg_fifo_en = 1'b1;
  logic cfg_par_en = 1'b1, cfg_stuff_sel = 1'b1, cfg_wide8 = 1'b1, cfg_irq_en = 1'b1;
  logic ninth_wr = 1'b0, ninth_val = 1'b0, host_wr = 1'b0;
  logic [7:0] host_byte = '0;
  logic irq_ack = 1'b0, flag_clr = 1'b0, ser_in = 1'b0, ser_pop = 1'b0;
  logic [8:0] pop_data;
  logic tx_bit, src_fifo, not_full, half_full, irq, overflow, underrun;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  host_tx_fifo u_dut (
    .clk(clk), .rst(rst), .cfg_par_mode(cfg_par_mode), .cfg_hdlc(cfg_hdlc),
    .cfg_fifo_en(cfg_fifo_en), .cfg_par_en(cfg_par_en), .cfg_stuff_sel(cfg_stuff_sel),
    .cfg_wide8(cfg_wide8), .cfg_irq_en(cfg_irq_en), .ninth_wr(ninth_wr),
    .ninth_val(ninth_val), .host_wr(host_wr), .host_byte(host_byte),
    .irq_ack(irq_ack), .flag_clr(flag_clr), .ser_in(ser_in), .ser_pop(ser_pop),
    .pop_data(pop_data), .tx_bit(tx_bit), .src_fifo(src_fifo), .not_full(not_full),
    .half_full(half_full), .irq(irq), .overflow(overflow), .underrun(underrun)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stage(input logic v);
    ninth_val = v; ninth_wr = 1'b1; tick(); ninth_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    host_byte = b; host_wr = 1'b1; tick(); host_wr = 1'b0;
  endtask

  task automatic pop();
    ser_pop = 1'b1; tick(); ser_pop = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic clr();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 not_full", not_full, 1);
    chk("R1 half_full", half_full, 0);
    chk("R1 irq", irq, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 pop_data", pop_data, 0);

    // Fill sweep: R3, R4, R5 rising
    for (int i = 0; i < 16; i++) begin
      stage(i[0]);
      push(8'(i * 7 + 3));
      chk("R3 half on fill", half_full, (i + 1) >= 8);
      chk("R4 not_full on fill", not_full, (i + 1) < 16);
      chk("R5 irq on fill", irq, i == 7);
      if (i == 7) begin
        ack();
        chk("R5 ack clears", irq, 0);
      end
    end
    push(8'hEE);
    chk("R9 overflow set", overflow, 1);
    chk("R9 still full", not_full, 0);

    // Drain sweep: R2 order, R3, R5 falling, R9 contents unchanged
    for (int i = 0; i < 16; i++) begin
      pop();
      chk("R2 order", pop_data, {i[0], 8'(i * 7 + 3)});
      chk("R3 half on drain", half_full, (15 - i) >= 8);
      chk("R5 irq on drain", irq, (15 - i) == 7);
      if (15 - i == 7) ack();
    end
    chk("R4 not_full empty", not_full, 1);

    // R10 empty pop
    pop();
    chk("R10 data held", pop_data, {1'b1, 8'(15 * 7 + 3)});
    chk("R10 underrun", underrun, 1);
    chk("R11 overflow sticky", overflow, 1);
    clr();
    chk("R11 overflow cleared", overflow, 0);
    chk("R11 underrun cleared", underrun, 0);

    // R6 ninth-bit conditions sweep
    for (int m = 0; m < 8; m++) begin
      cfg_par_en = m[0]; cfg_stuff_sel = m[1]; cfg_wide8 = m[2];
      stage(1'b1);
      push(8'hA5);
      pop();
      chk("R6 ninth gating", pop_data, {m == 7, 8'hA5});
    end

    // R5 masked
    cfg_irq_en = 1'b0;
    for (int i = 0; i < 8; i++) push(8'(i));
    chk("R5 masked half", half_full, 1);
    chk("R5 masked rise", irq, 0);
    for (int i = 0; i < 8; i++) pop();
    chk("R5 masked fall", irq, 0);
    chk("R2 masked last", pop_data, {1'b1, 8'd7});
    cfg_irq_en = 1'b1;

    // R8 single holding entry
    cfg_fifo_en = 1'b0;
    stage(1'b0);
    push(8'h11);
    chk("R8 not_full single", not_full, 0);
    chk("R8 half stays 0", half_full, 0);
    push(8'h22);
    chk("R8 overflow single", overflow, 1);
    pop();
    chk("R8 holding data", pop_data, {1'b0, 8'h11});
    pop();
    chk("R8 single underrun", underrun, 1);
    clr();
    cfg_fifo_en = 1'b1;

    // R7 serial bypass
    cfg_par_mode = 1'b0;
    tick();
    chk("R7 src off", src_fifo, 0);
    for (int b = 0; b < 4; b++) begin
      ser_in = b[0] ^ b[1];
      tick();
      chk("R7 tx_bit follows", tx_bit, b[0] ^ b[1]);
    end
    push(8'h33);
    chk("R7 write ignored ovf", overflow, 0);
    pop();
    chk("R7 pop ignored", underrun, 0);
    chk("R7 pop_data unchanged", pop_data, {1'b0, 8'h11});
    cfg_hdlc = 1'b1;
    ser_in = 1'b1;
    tick();
    chk("R7 hdlc forces src", src_fifo, 1);
    chk("R7 tx_bit zero", tx_bit, 0);
    pop();
    chk("R7 serial write was dropped", underrun, 1);
    clr();
    push(8'h44);
    pop();
    chk("R7 hdlc path data", pop_data, {1'b0, 8'h44});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule